// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block makes the timing signals for a processor from one oscillator clock. A modulo-three phase counter divides the oscillator by three. The processor clock it produces is high for one oscillator cycle and low for two. A one-cycle enable pulse marks the oscillator cycle that ends with a processor-clock rising edge, so logic in the oscillator domain can act in step with the processor.

Two request lines arrive without any timing relation to that clock. The first is an active-low reset request. The second is a ready acknowledgement that slow memory or I/O raises when it can finish a transfer. Each request is sampled at a processor-clock rising edge. It reaches its output at the next processor-clock falling edge, so both outputs are settled a full low phase before the processor samples them. The processor takes wait states while the ready output is low.

While reset is in force, the ready output is held low. The divider never stops, so the processor keeps getting clock edges during reset. Every register runs on the oscillator clock. Processor-clock edges exist only as enables, and no logic is clocked by a derived clock. No stream of data passes through the block, so all pins are plain level signals with no valid/ready handshake.

Top module: `cpu_timing_gen`

## Requirements
- R1: `cpu_clk` repeats every `DIV_RATIO` (default 3) oscillator cycles. It rises exactly once per period.
- R2: `cpu_clk` is a registered output. It is high for exactly `HIGH_PHASES` (default 1) oscillator cycles of each period and low for the rest.
- R3: `clk_en` is high for exactly one oscillator cycle per period. That cycle is the one whose closing oscillator edge makes `cpu_clk` rise.
- R4: After power-up, `cpu_rst` is 1 and `cpu_rdy` is 0. `cpu_rst` is the inverse of `rst_req_n`: a 0 on the request asserts it and a 1 releases it. The request is sampled at a `cpu_clk` rising edge and shows at the next `cpu_clk` falling edge. With the default ratio, a change applied just after a rising edge appears 4 oscillator edges later and not earlier.
- R5: `cpu_rst` and `cpu_rdy` change only at oscillator edges where `cpu_clk` falls.
- R6: `cpu_rdy` follows `rdy_req` (1 = device ready) with the same sampling and latency as in R4. A 0 keeps the processor in wait states.
- R7: While `cpu_rst` is 1, `cpu_rdy` is 0 whatever the ready request is. When reset releases, a ready request that is already high shows on the same edge where `cpu_rst` falls.
- R8: The divider keeps running while reset is requested (R1 to R3 hold during reset). A ready request that is high only between two rising edges of `cpu_clk` never reaches `cpu_rdy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; every register in the block runs on it |
| rst_req_n | input | 1 | Raw reset request, active low, asynchronous |
| rdy_req | input | 1 | Raw ready acknowledgement from the addressed device, active high, asynchronous |
| cpu_clk | output | 1 | Processor clock, oscillator divided by DIV_RATIO, high HIGH_PHASES cycles |
| clk_en | output | 1 | One-cycle pulse in the oscillator cycle before each cpu_clk rising edge |
| cpu_rst | output | 1 | Conditioned reset, active high, changes on cpu_clk falling edges |
| cpu_rdy | output | 1 | Synchronized ready, active high, changes on cpu_clk falling edges |

## Verification
The bench changes requests and reads outputs on oscillator falling edges. Each scenario first aligns to the falling edge that follows a `cpu_clk` rise, which fixes where the divider phase stands. From that point the rising edge that samples a request comes 3 oscillator edges later, and the output changes at the 4th. The bench therefore reads each reset or ready output twice: after 3 edges, when the old value must remain, and after 4 edges, when the new value is due. The divider checks read `cpu_clk` and `clk_en` on each of 9 consecutive cycles after alignment. They compare these samples with the fixed pattern 1,0,0 for the clock and 0,0,1 for the enable. The same comparison is repeated while reset is held. The short-pulse case raises and drops ready between two rising edges, then confirms that the output stays low over the next two periods.

// File: rtl/cpu_timing_pkg.sv
package cpu_timing_pkg;

  // Default division ratio and high-phase length of the processor clock.
  localparam int unsigned DEF_DIV_RATIO   = 3;
  localparam int unsigned DEF_HIGH_PHASES = 1;

  // Strobes, valid for one oscillator cycle, that announce what the
  // processor clock does at the closing oscillator edge of that cycle.
  typedef struct packed {
    logic rise;  // cpu_clk goes 0 -> 1 at the coming edge
    logic fall;  // cpu_clk goes 1 -> 0 at the coming edge
  } cpu_edge_t;

endpackage

// File: rtl/clk_divider.sv
module clk_divider
  import cpu_timing_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = DEF_DIV_RATIO,
  parameter int unsigned HIGH_PHASES = DEF_HIGH_PHASES
) (
  input  logic      osc_clk,
  output logic      cpu_clk,
  output logic      clk_en,
  output cpu_edge_t edges
);

  localparam int unsigned CNT_W     = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] HEND = CNT_W'(HIGH_PHASES - 1);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(DIV_RATIO - 2);

  // Phase counter: starts at the last phase so the first edge is a rise.
  logic [CNT_W-1:0] cnt_q = LAST;
  logic [CNT_W-1:0] cnt_nxt;
  logic             clk_q = 1'b0;
  logic             en_q  = 1'b0;

  // Any value above LAST (never reached) falls back to phase 0.
  always_comb begin
    if (cnt_q >= LAST) cnt_nxt = '0;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  // Clock and enable are registered so neither can glitch on a decode.
  always_ff @(posedge osc_clk) begin
    cnt_q <= cnt_nxt;
    clk_q <= (cnt_nxt <= HEND);
    en_q  <= (cnt_nxt == LAST);
  end

  assign cpu_clk    = clk_q;
  assign clk_en     = en_q;
  assign edges.rise = (cnt_q == LAST);
  assign edges.fall = (cnt_q == HEND);

  // ---------------- checks ----------------
  logic       primed_q = 1'b0;
  logic       seen_q   = 1'b0;
  logic       prev_q   = 1'b0;
  logic [7:0] per_q    = '0;
  logic [7:0] hi_q     = '0;
  logic       up_now;
  logic       dn_now;

  assign up_now = clk_q & ~prev_q;
  assign dn_now = ~clk_q & prev_q;

  always_ff @(posedge osc_clk) begin
    primed_q <= 1'b1;
    prev_q   <= clk_q;
    if (up_now) seen_q <= 1'b1;
    per_q <= up_now ? 8'd1 : per_q + 8'd1;
    hi_q  <= clk_q ? hi_q + 8'd1 : 8'd0;
  end

  // R1
  period_len_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    (up_now && seen_q) |-> (per_q == 8'(DIV_RATIO)));

  // R2
  high_len_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    (dn_now && seen_q) |-> (hi_q == 8'(HIGH_PHASES)));

  // R3
  en_before_rise_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    clk_en |=> $rose(cpu_clk));

  // R3
  en_single_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    clk_en |=> !clk_en);

endmodule

// File: rtl/rst_conditioner.sv
module rst_conditioner
  import cpu_timing_pkg::*;
(
  input  logic      osc_clk,
  input  cpu_edge_t edges,
  input  logic      rst_req_n,
  output logic      rst_pend,
  output logic      cpu_rst
);

  // Stage one samples at processor rising edges; stage two releases on
  // processor falling edges. Both power up in reset.
  logic st1_q = 1'b1;
  logic st2_q = 1'b1;

  always_ff @(posedge osc_clk) begin
    if (edges.rise) st1_q <= ~rst_req_n;
    if (edges.fall) st2_q <= st1_q;
  end

  assign rst_pend = st1_q;
  assign cpu_rst  = st2_q;

  logic primed_q = 1'b0;
  always_ff @(posedge osc_clk) primed_q <= 1'b1;

  // R5
  rst_on_fall_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    (cpu_rst != $past(cpu_rst)) |-> $past(edges.fall));

  // R4
  rst_from_stage_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    $past(edges.fall) |-> (cpu_rst == $past(rst_pend)));

endmodule

// File: rtl/rdy_synchronizer.sv
module rdy_synchronizer
  import cpu_timing_pkg::*;
(
  input  logic      osc_clk,
  input  cpu_edge_t edges,
  input  logic      rdy_req,
  input  logic      rst_pend,
  output logic      cpu_rdy
);

  logic st1_q = 1'b0;
  logic st2_q = 1'b0;

  // The pending reset clears ready on the same edge that raises cpu_rst.
  always_ff @(posedge osc_clk) begin
    if (edges.rise) st1_q <= rdy_req;
    if (edges.fall) st2_q <= st1_q & ~rst_pend;
  end

  assign cpu_rdy = st2_q;

  logic primed_q = 1'b0;
  always_ff @(posedge osc_clk) primed_q <= 1'b1;

  // R5
  rdy_on_fall_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    (cpu_rdy != $past(cpu_rdy)) |-> $past(edges.fall));

  // R6
  rdy_hold_chk: assert property (@(posedge osc_clk) disable iff (!primed_q)
    !$past(edges.fall) |-> $stable(cpu_rdy));

endmodule

// File: rtl/cpu_timing_gen.sv
module cpu_timing_gen
  import cpu_timing_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = DEF_DIV_RATIO,
  parameter int unsigned HIGH_PHASES = DEF_HIGH_PHASES
) (
  input  logic osc_clk,
  input  logic rst_req_n,
  input  logic rdy_req,
  output logic cpu_clk,
  output logic clk_en,
  output logic cpu_rst,
  output logic cpu_rdy
);

  cpu_edge_t edges;
  logic      rst_pend;

  clk_divider #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_PHASES(HIGH_PHASES)
  ) u_div (
    .osc_clk(osc_clk),
    .cpu_clk(cpu_clk),
    .clk_en (clk_en),
    .edges  (edges)
  );

  rst_conditioner u_rst (
    .osc_clk  (osc_clk),
    .edges    (edges),
    .rst_req_n(rst_req_n),
    .rst_pend (rst_pend),
    .cpu_rst  (cpu_rst)
  );

  rdy_synchronizer u_rdy (
    .osc_clk (osc_clk),
    .edges   (edges),
    .rdy_req (rdy_req),
    .rst_pend(rst_pend),
    .cpu_rdy (cpu_rdy)
  );

  // R7
  rst_blocks_rdy_chk: assert property (@(posedge osc_clk)
    cpu_rst |-> !cpu_rdy);

endmodule

// File: tb/tb_cpu_timing_gen.sv
`timescale 1ns/1ps
module tb_cpu_timing_gen;

  logic osc_clk = 1'b0;
  logic rst_req_n;
  logic rdy_req;
  logic cpu_clk, clk_en, cpu_rst, cpu_rdy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 osc_clk = ~osc_clk;  // 125 MHz

  cpu_timing_gen dut (
    .osc_clk  (osc_clk),
    .rst_req_n(rst_req_n),
    .rdy_req  (rdy_req),
    .cpu_clk  (cpu_clk),
    .clk_en   (clk_en),
    .cpu_rst  (cpu_rst),
    .cpu_rdy  (cpu_rdy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Stop on the falling oscillator edge just after a cpu_clk rise.
  task automatic align_rise();
    do @(negedge osc_clk); while (cpu_clk !== 1'b0);
    do @(negedge osc_clk); while (cpu_clk !== 1'b1);
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  // R1 R2 R3: clock 1,0,0 and enable 0,0,1 across three periods.
  task automatic t_divider(input string tag);
    align_rise();
    for (int k = 0; k < 9; k++) begin
      check({tag, " R1/R2 cpu_clk"}, cpu_clk, (k % 3) == 0);
      check({tag, " R3 clk_en"}, clk_en, (k % 3) == 2);
      @(negedge osc_clk);
    end
  endtask

  // R4: reset request change shows 4 edges after a post-rise stimulus.
  task automatic t_reset_latency(input logic req_n);
    align_rise();
    rst_req_n = req_n;
    skip(3);
    check("R4 rst before due", cpu_rst, req_n);
    skip(1);
    check("R4 rst at due", cpu_rst, ~req_n);
  endtask

  // R6: ready request latency, also R5 (no change before falling edge).
  task automatic t_ready_latency(input logic val);
    align_rise();
    rdy_req = val;
    skip(3);
    check("R5/R6 rdy before due", cpu_rdy, ~val);
    skip(1);
    check("R6 rdy at due", cpu_rdy, val);
  endtask

  // R7: ready forced low in reset, released together with reset.
  task automatic t_reset_masks_ready();
    align_rise();
    rdy_req   = 1'b1;
    rst_req_n = 1'b0;
    skip(4);
    check("R7 rst asserted", cpu_rst, 1'b1);
    check("R7 rdy forced low", cpu_rdy, 1'b0);
    t_divider("R8 in reset");
    align_rise();
    rst_req_n = 1'b1;
    skip(3);
    check("R7 rdy still low", cpu_rdy, 1'b0);
    skip(1);
    check("R7 rst released", cpu_rst, 1'b0);
    check("R7 rdy with release", cpu_rdy, 1'b1);
  endtask

  // R8: a ready pulse that misses every rising edge is not seen.
  task automatic t_short_pulse();
    align_rise();
    rdy_req = 1'b0;
    skip(6);
    check("R8 rdy idle low", cpu_rdy, 1'b0);
    align_rise();
    rdy_req = 1'b1;
    skip(1);
    rdy_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      skip(1);
      check("R8 short pulse ignored", cpu_rdy, 1'b0);
    end
  endtask

  initial begin
    rst_req_n = 1'b0;
    rdy_req   = 1'b0;
    @(negedge osc_clk);
    check("R4 power-up rst", cpu_rst, 1'b1);
    check("R4 power-up rdy", cpu_rdy, 1'b0);
    t_divider("R1 base");
    t_reset_latency(1'b1);
    t_reset_latency(1'b0);
    t_reset_latency(1'b1);
    t_ready_latency(1'b1);
    t_ready_latency(1'b0);
    t_reset_masks_ready();
    rdy_req = 1'b0;
    t_short_pulse();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge osc_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule